// File: doc/BRIEF.md
# Sensor Timing Mode Register Port

This block is the write-only configuration port of an image-sensor timing generator. A host sends 48-bit frames over three wires: a data line, a serial clock and a strobe. Each frame carries an 8-bit chip-select code and a 2-bit category. The category picks one of two register banks. The control bank holds the drive mode, the sync pattern, shutter and clamp options, the ADC clock phase and the power state. The shutter bank holds the vertical count, the horizontal count and the placement of the shutter window.

Bits that have been received are not applied straight away. They sit in shadow registers until the event that suits them. The power-state field is applied as soon as the strobe rises. The drive mode and the pattern bit wait for the falling edge of the frame sync. Every other field waits for the falling edge of the line sync in a readout line. An inhibit input, which the exposure logic drives while a long shutter is running, holds back both sync-driven updates. The shadow values are kept, and they are applied at the first qualifying event after the inhibit is released.

All inputs are sampled on the system clock. Edges are found by comparing each input with its value at the previous clock. Each active register changes on the clock edge that first samples its event.

Top module: `tg_mode_regs`

## Requirements
- R1: While reset is held, and afterwards until a write is applied, every output is zero except `adc_phase`, which is 01 (90 degrees).
- R2: Data is shifted on rising edges of `ser_clk` while `ser_stb` is low, bit D00 first. A frame is accepted only if exactly 48 such edges have been counted when `ser_stb` rises. With 47 or 49 edges the frame is discarded.
- R3: A frame is accepted only if bits D07..D00 equal 1000_0001: D00 and D07 are one and the bits between are zero. Any other code discards the frame.
- R4: The category {D09,D08} selects the destination. 00 writes the control bank. 01 writes the shutter bank. 10 and 11 write nothing.
- R5: When a bank is written twice before its apply event, the later frame's values are the ones applied.
- R6: `drive_mode` takes D12..D10 and `pal_pattern` takes D15. They change only on the clock that samples `frame_sync_n` going low while `upd_hold` is low.
- R7: `pwr_mode` is updated on the clock that samples the `ser_stb` rise of an accepted control frame. It decodes {D39,D38} as follows: x0 gives 0 (run), 01 gives 1 (sleep), 11 gives 2 (standby). `upd_hold` has no effect on it, and the value 3 never appears.
- R8: Six fields change only on the clock that samples `line_sync_n` going low while `readout_line` is high and `upd_hold` is low. They are `shut_enable` (D13), `readout_inhibit` (D14), `wide_clamp` (D32), `exp_select` (D33), `clamp_pattern` (D35..D34) and `adc_phase` (D37..D36).
- R9: `shut_vcount` takes D19..D10, `shut_hcount` takes D31..D20 and `shut_vplace` takes D41..D32. All three are applied from the shutter bank at the same event as R8.
- R10: While `upd_hold` is high, line and frame events apply nothing. The shadow contents survive and are applied at the first qualifying event after `upd_hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_stb | input | 1 | Serial strobe; low while a frame is sent, rising edge ends the frame |
| line_sync_n | input | 1 | Line sync; falling edge is the line event |
| frame_sync_n | input | 1 | Frame sync; falling edge is the frame event |
| readout_line | input | 1 | High during the readout line |
| upd_hold | input | 1 | Inhibits the sync-driven updates |
| drive_mode | output | 3 | Drive mode: 000 draft, 001 frame A, 010 frame B, 011 frame, 10x AF1, 11x AF2 |
| pal_pattern | output | 1 | Sync pattern: 0 NTSC-like, 1 PAL-like |
| pwr_mode | output | 2 | Power state: 0 run, 1 sleep, 2 standby |
| shut_enable | output | 1 | Electronic shutter enable |
| readout_inhibit | output | 1 | Suppresses the readout pulse |
| wide_clamp | output | 1 | Wide clamp enable |
| exp_select | output | 1 | Selects the exposure pulse instead of the line ID |
| clamp_pattern | output | 2 | Clamp waveform pattern |
| adc_phase | output | 2 | ADC clock phase in steps of 90 degrees |
| shut_vcount | output | 10 | Shutter vertical-period count |
| shut_hcount | output | 12 | Shutter horizontal-period count |
| shut_vplace | output | 10 | Shutter placement period within the vertical count |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that each serial clock phase lasts at least one clock, so every edge is seen once, and that no serial clock rise falls in the same cycle as a strobe rise. A sync event and a frame acceptance are likewise never sampled in the same cycle. The stimulus meets all of this by holding each serial clock phase for one or two clocks and by issuing strobes and sync pulses from separate tasks, with idle clocks between them.

// File: rtl/tgm_pkg.sv
// Package: field positions, widths and shared types for the mode register port.
// Assumes frames are numbered D00 (first bit shifted) upward.
package tgm_pkg;
    localparam int FRAME_W  = 48;
    localparam int ID_W     = 8;
    localparam logic [ID_W-1:0] CHIP_ID_DEF = 8'b1000_0001;
    localparam int CAT_LO   = 8;
    localparam int CAT_W    = 2;
    localparam int USED_W   = 42;       // highest decoded bit + 1

    localparam int MODE_LO  = 10;
    localparam int MODE_W   = 3;
    localparam int SHEN_BIT = 13;
    localparam int RDIN_BIT = 14;
    localparam int PAL_BIT  = 15;
    localparam int WIDE_BIT = 32;
    localparam int EXP_BIT  = 33;
    localparam int CLMP_LO  = 34;
    localparam int PHS_LO   = 36;
    localparam int PWR_LO   = 38;

    localparam int SVD_LO   = 10;
    localparam int SVD_W    = 10;
    localparam int SHD_LO   = 20;
    localparam int SHD_W    = 12;
    localparam int SPL_LO   = 32;
    localparam int SPL_W    = 10;

    localparam logic [CAT_W-1:0] CAT_CTL = 2'b00;
    localparam logic [CAT_W-1:0] CAT_SHT = 2'b01;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_SLEEP = 2'd1,
        PWR_STBY  = 2'd2
    } pwr_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              pal;
    } frame_ctl_t;

    typedef struct packed {
        logic       shut_en;
        logic       rd_inh;
        logic       wide;
        logic       exp_sel;
        logic [1:0] clamp;
        logic [1:0] phase;
    } line_ctl_t;

    typedef struct packed {
        logic [SVD_W-1:0] svd;
        logic [SHD_W-1:0] shd;
        logic [SPL_W-1:0] spl;
    } shut_t;

    localparam line_ctl_t LINE_CTL_RST = '{shut_en: 1'b0, rd_inh: 1'b0, wide: 1'b0,
                                          exp_sel: 1'b0, clamp: 2'b00, phase: 2'b01};

    // Map the two standby bits {hi,lo} onto the power state.
    function automatic pwr_e decode_pwr(input logic [1:0] f);
        if (!f[0])      return PWR_RUN;
        else if (!f[1]) return PWR_SLEEP;
        else            return PWR_STBY;
    endfunction
endpackage

// File: rtl/tgm_edge_det.sv
// Edge detector: registers each input once and flags, per bit, the rising
// edge (RISE_MASK bit set) or the falling edge (bit clear).
// Assumes the inputs are already synchronous to clk; the previous-value
// register resets high, so no false edge appears on idle-high lines.
module tgm_edge_det #(
    parameter int             N         = 4,
    parameter logic [N-1:0]   RISE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] prev_q;

    // Hold the value seen at the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sig_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (RISE_MASK[g]) begin : g_rise
            assign evt_o[g] = sig_i[g] & ~prev_q[g];
        end else begin : g_fall
            assign evt_o[g] = ~sig_i[g] & prev_q[g];
        end
    end
endmodule

// File: rtl/tgm_serial_rx.sv
// Serial receiver: shifts data on serial clock rises while the strobe is low,
// D00 first, and flags a frame as good on the strobe rise when exactly
// FRAME_BITS edges were counted and the chip code matches.
// Assumes a serial clock rise never coincides with a strobe rise.
module tgm_serial_rx
    import tgm_pkg::*;
#(
    parameter int              FRAME_BITS = FRAME_W,
    parameter int              OUT_W      = USED_W,
    parameter logic [ID_W-1:0] CHIP_ID    = CHIP_ID_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             ser_stb,
    input  logic             sclk_rise,
    input  logic             stb_rise,
    output logic             frame_ok_o,
    output logic [OUT_W-1:0] word_o
);
    localparam int               CNT_W    = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      cnt_q;

    // Shift in data and count edges; the strobe rise restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (stb_rise) begin
            cnt_q   <= '0;
        end else if (sclk_rise && !ser_stb) begin
            shift_q <= {ser_data, shift_q[FRAME_BITS-1:1]};
            if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign frame_ok_o = stb_rise && (cnt_q == CNT_FULL) && (shift_q[ID_W-1:0] == CHIP_ID);
    assign word_o     = shift_q[OUT_W-1:0];
endmodule

// File: rtl/tgm_reg_stage.sv
// Register stage: keeps shadow copies of both banks and moves them to the
// active registers at their own events; the power state is taken at once.
// Assumes a sync event never falls in the same cycle as a frame acceptance.
module tgm_reg_stage
    import tgm_pkg::*;
#(
    parameter int PAY_W = USED_W - CAT_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ok_i,
    input  logic [PAY_W-1:0] pay_i,       // frame bits D08 upward
    input  logic             line_evt_i,
    input  logic             frame_evt_i,
    input  logic             readout_i,
    input  logic             hold_i,
    output frame_ctl_t       frame_ctl_o,
    output line_ctl_t        line_ctl_o,
    output shut_t            shut_o,
    output pwr_e             pwr_o
);
    localparam int B = CAT_LO;

    frame_ctl_t fr_sh, fr_q;
    line_ctl_t  ln_sh, ln_q;
    shut_t      st_sh, st_q;
    pwr_e       pwr_q;

    logic [CAT_W-1:0] cat;
    logic             wr_ctl, wr_sht, line_go, frame_go;

    assign cat      = pay_i[CAT_LO-B +: CAT_W];
    assign wr_ctl   = frame_ok_i && (cat == CAT_CTL);
    assign wr_sht   = frame_ok_i && (cat == CAT_SHT);
    assign line_go  = line_evt_i && readout_i && !hold_i;
    assign frame_go = frame_evt_i && !hold_i;

    // Capture accepted frames into the shadow copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_sh <= '0;
            ln_sh <= LINE_CTL_RST;
            st_sh <= '0;
        end else begin
            if (wr_ctl) begin
                fr_sh <= '{mode: pay_i[MODE_LO-B +: MODE_W], pal: pay_i[PAL_BIT-B]};
                ln_sh <= '{shut_en: pay_i[SHEN_BIT-B], rd_inh: pay_i[RDIN_BIT-B],
                           wide: pay_i[WIDE_BIT-B], exp_sel: pay_i[EXP_BIT-B],
                           clamp: pay_i[CLMP_LO-B +: 2], phase: pay_i[PHS_LO-B +: 2]};
            end
            if (wr_sht) begin
                st_sh <= '{svd: pay_i[SVD_LO-B +: SVD_W], shd: pay_i[SHD_LO-B +: SHD_W],
                           spl: pay_i[SPL_LO-B +: SPL_W]};
            end
        end
    end

    // Apply line-timed fields and shutter values in the readout line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= LINE_CTL_RST;
            st_q <= '0;
        end else if (line_go) begin
            ln_q <= ln_sh;
            st_q <= st_sh;
        end
    end

    // Apply drive mode and pattern at the frame event.
    always_ff @(posedge clk) begin
        if (!rst_n)        fr_q <= '0;
        else if (frame_go) fr_q <= fr_sh;
    end

    // Power state follows an accepted control frame immediately.
    always_ff @(posedge clk) begin
        if (!rst_n)      pwr_q <= PWR_RUN;
        else if (wr_ctl) pwr_q <= decode_pwr(pay_i[PWR_LO-B +: 2]);
    end

    assign frame_ctl_o = fr_q;
    assign line_ctl_o  = ln_q;
    assign shut_o      = st_q;
    assign pwr_o       = pwr_q;
endmodule

// File: rtl/tg_mode_regs.sv
// Top: three-wire mode register port with staged update of the control and
// shutter banks. Assumes all inputs are synchronous to clk.
module tg_mode_regs
    import tgm_pkg::*;
#(
    parameter int              FRAME_BITS = FRAME_W,
    parameter logic [ID_W-1:0] CHIP_ID    = CHIP_ID_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_stb,
    input  logic              line_sync_n,
    input  logic              frame_sync_n,
    input  logic              readout_line,
    input  logic              upd_hold,
    output logic [MODE_W-1:0] drive_mode,
    output logic              pal_pattern,
    output logic [1:0]        pwr_mode,
    output logic              shut_enable,
    output logic              readout_inhibit,
    output logic              wide_clamp,
    output logic              exp_select,
    output logic [1:0]        clamp_pattern,
    output logic [1:0]        adc_phase,
    output logic [SVD_W-1:0]  shut_vcount,
    output logic [SHD_W-1:0]  shut_hcount,
    output logic [SPL_W-1:0]  shut_vplace
);
    localparam int NSIG  = 4;                  // {frame, line, strobe, sclk}
    localparam int PAY_W = USED_W - CAT_LO;

    logic [NSIG-1:0]   evt;
    logic              frame_ok;
    logic [USED_W-1:0] word;
    frame_ctl_t        fr;
    line_ctl_t         ln;
    shut_t             st;
    pwr_e              pwr;

    tgm_edge_det #(.N(NSIG), .RISE_MASK(4'b0011)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i ({frame_sync_n, line_sync_n, ser_stb, ser_clk}),
        .evt_o (evt)
    );

    tgm_serial_rx #(.FRAME_BITS(FRAME_BITS), .OUT_W(USED_W), .CHIP_ID(CHIP_ID)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data   (ser_data),
        .ser_stb    (ser_stb),
        .sclk_rise  (evt[0]),
        .stb_rise   (evt[1]),
        .frame_ok_o (frame_ok),
        .word_o     (word)
    );

    tgm_reg_stage #(.PAY_W(PAY_W)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok_i  (frame_ok),
        .pay_i       (word[USED_W-1:CAT_LO]),
        .line_evt_i  (evt[2]),
        .frame_evt_i (evt[3]),
        .readout_i   (readout_line),
        .hold_i      (upd_hold),
        .frame_ctl_o (fr),
        .line_ctl_o  (ln),
        .shut_o      (st),
        .pwr_o       (pwr)
    );

    assign drive_mode      = fr.mode;
    assign pal_pattern     = fr.pal;
    assign pwr_mode        = pwr;
    assign shut_enable     = ln.shut_en;
    assign readout_inhibit = ln.rd_inh;
    assign wide_clamp      = ln.wide;
    assign exp_select      = ln.exp_sel;
    assign clamp_pattern   = ln.clamp;
    assign adc_phase       = ln.phase;
    assign shut_vcount     = st.svd;
    assign shut_hcount     = st.shd;
    assign shut_vplace     = st.spl;
endmodule

// File: rtl/tgm_regs_chk.sv
// Checker: port-level timing properties of the mode register port.
// Assumes synchronous inputs, as stated in the brief.
module tgm_regs_chk
    import tgm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ser_stb,
    input logic              line_sync_n,
    input logic              frame_sync_n,
    input logic              readout_line,
    input logic              upd_hold,
    input logic [MODE_W-1:0] drive_mode,
    input logic              pal_pattern,
    input logic [1:0]        pwr_mode,
    input logic              shut_enable,
    input logic              readout_inhibit,
    input logic              wide_clamp,
    input logic              exp_select,
    input logic [1:0]        clamp_pattern,
    input logic [1:0]        adc_phase,
    input logic [SVD_W-1:0]  shut_vcount,
    input logic [SHD_W-1:0]  shut_hcount,
    input logic [SPL_W-1:0]  shut_vplace
);
    logic seen_q = 1'b0;

    // Marks that one clock has passed, so $past has a real sample.
    always_ff @(posedge clk) seen_q <= 1'b1;

    p_reset_vals_r1: assert property (@(posedge clk)
        (seen_q && $past(!rst_n)) |-> (adc_phase == 2'b01 && drive_mode == '0 &&
                                       pwr_mode == '0 && shut_vcount == '0 && exp_select == 1'b0));

    p_mode_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(frame_sync_n) && !upd_hold) |=> ($stable(drive_mode) && $stable(pal_pattern)));

    p_pwr_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ser_stb) |=> $stable(pwr_mode));

    p_pwr_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 2'd3);

    p_line_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(line_sync_n) && readout_line && !upd_hold) |=>
        $stable({shut_enable, readout_inhibit, wide_clamp, exp_select, clamp_pattern, adc_phase}));

    p_shut_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !($fell(line_sync_n) && readout_line && !upd_hold) |=>
        $stable({shut_vcount, shut_hcount, shut_vplace}));

    p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hold |=> ($stable(drive_mode) && $stable(adc_phase) && $stable(shut_hcount)));
endmodule

bind tg_mode_regs tgm_regs_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ser_stb         (ser_stb),
    .line_sync_n     (line_sync_n),
    .frame_sync_n    (frame_sync_n),
    .readout_line    (readout_line),
    .upd_hold        (upd_hold),
    .drive_mode      (drive_mode),
    .pal_pattern     (pal_pattern),
    .pwr_mode        (pwr_mode),
    .shut_enable     (shut_enable),
    .readout_inhibit (readout_inhibit),
    .wide_clamp      (wide_clamp),
    .exp_select      (exp_select),
    .clamp_pattern   (clamp_pattern),
    .adc_phase       (adc_phase),
    .shut_vcount     (shut_vcount),
    .shut_hcount     (shut_hcount),
    .shut_vplace     (shut_vplace)
);

// File: tb/tg_mode_regs_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks with fixed expected values for each requirement.
module tg_mode_regs_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_stb = 1'b1;
    logic line_sync_n = 1'b1, frame_sync_n = 1'b1, readout_line = 1'b0, upd_hold = 1'b0;

    logic [2:0]  drive_mode;
    logic        pal_pattern, shut_enable, readout_inhibit, wide_clamp, exp_select;
    logic [1:0]  pwr_mode, clamp_pattern, adc_phase;
    logic [9:0]  shut_vcount, shut_vplace;
    logic [11:0] shut_hcount;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tg_mode_regs dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_stb(ser_stb),
        .line_sync_n(line_sync_n), .frame_sync_n(frame_sync_n), .readout_line(readout_line),
        .upd_hold(upd_hold), .drive_mode(drive_mode), .pal_pattern(pal_pattern),
        .pwr_mode(pwr_mode), .shut_enable(shut_enable), .readout_inhibit(readout_inhibit),
        .wide_clamp(wide_clamp), .exp_select(exp_select), .clamp_pattern(clamp_pattern),
        .adc_phase(adc_phase), .shut_vcount(shut_vcount), .shut_hcount(shut_hcount),
        .shut_vplace(shut_vplace)
    );

    task automatic chk(string req, string nm, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [47:0] m_cf, m_sf;               // last accepted control / shutter frames
    bit          q[$];                     // bits received in the current frame
    logic        p_sclk, p_stb, p_line, p_frame;
    int m_mode, m_pal, m_pwr, m_sen, m_rdi, m_wide, m_exp, m_clamp, m_phase, m_svd, m_shd, m_spl;
    bit m_started = 1'b0;

    always @(posedge clk) begin
        logic [47:0] w;
        if (!rst_n) begin
            m_cf = '0; m_cf[37:36] = 2'b01; m_sf = '0; q.delete();
            p_sclk = 1; p_stb = 1; p_line = 1; p_frame = 1;
            m_mode = 0; m_pal = 0; m_pwr = 0; m_sen = 0; m_rdi = 0; m_wide = 0; m_exp = 0;
            m_clamp = 0; m_phase = 1; m_svd = 0; m_shd = 0; m_spl = 0;
        end else begin
            if (!line_sync_n && p_line && readout_line && !upd_hold) begin
                m_sen = m_cf[13]; m_rdi = m_cf[14]; m_wide = m_cf[32]; m_exp = m_cf[33];
                m_clamp = m_cf[35:34]; m_phase = m_cf[37:36];
                m_svd = m_sf[19:10]; m_shd = m_sf[31:20]; m_spl = m_sf[41:32];
            end
            if (!frame_sync_n && p_frame && !upd_hold) begin
                m_mode = m_cf[12:10]; m_pal = m_cf[15];
            end
            if (ser_stb && !p_stb) begin
                if (q.size() == 48) begin
                    for (int i = 0; i < 48; i++) w[i] = q[i];
                    if (w[7:0] == 8'b1000_0001) begin
                        if (w[9:8] == 2'b00) begin
                            m_cf = w;
                            m_pwr = !w[38] ? 0 : (!w[39] ? 1 : 2);
                        end else if (w[9:8] == 2'b01) begin
                            m_sf = w;
                        end
                    end
                end
                q.delete();
            end else if (ser_clk && !p_sclk && !ser_stb) begin
                if (q.size() < 60) q.push_back(ser_data);
            end
            p_sclk = ser_clk; p_stb = ser_stb; p_line = line_sync_n; p_frame = frame_sync_n;
        end
        m_started = 1'b1;
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (m_started && rst_n && !done) begin
            chk("R6", "drive_mode", drive_mode, m_mode);
            chk("R6", "pal_pattern", pal_pattern, m_pal);
            chk("R7", "pwr_mode", pwr_mode, m_pwr);
            chk("R8", "line fields", {shut_enable, readout_inhibit, wide_clamp, exp_select,
                clamp_pattern, adc_phase}, {m_sen[0], m_rdi[0], m_wide[0], m_exp[0],
                m_clamp[1:0], m_phase[1:0]});
            chk("R9", "shutter", {shut_vcount, shut_hcount, shut_vplace},
                {m_svd[9:0], m_shd[11:0], m_spl[9:0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [63:0] w, int n);
        ser_stb = 1'b0; tick(1);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i]; tick(1);
            ser_clk = 1'b1;  tick(2);
            ser_clk = 1'b0;  tick(1);
        end
        ser_stb = 1'b1; tick(2);
    endtask

    function automatic logic [63:0] ctl_word(logic [2:0] mode, logic pal, logic sen, logic rdi,
            logic wide, logic expo, logic [1:0] clamp, logic [1:0] phase, logic [1:0] stby,
            logic [7:0] id, logic [1:0] cat);
        logic [63:0] w = '0;
        w[7:0] = id; w[9:8] = cat; w[12:10] = mode; w[13] = sen; w[14] = rdi; w[15] = pal;
        w[32] = wide; w[33] = expo; w[35:34] = clamp; w[37:36] = phase; w[39:38] = stby;
        return w;
    endfunction

    function automatic logic [63:0] sht_word(logic [9:0] svd, logic [11:0] shd, logic [9:0] spl);
        logic [63:0] w = '0;
        w[7:0] = 8'b1000_0001; w[9:8] = 2'b01; w[19:10] = svd; w[31:20] = shd; w[41:32] = spl;
        return w;
    endfunction

    task automatic line_pulse(logic ro);
        readout_line = ro; line_sync_n = 1'b0; tick(2);
        line_sync_n = 1'b1; readout_line = 1'b0; tick(1);
    endtask

    task automatic frame_pulse();
        frame_sync_n = 1'b0; tick(2); frame_sync_n = 1'b1; tick(1);
    endtask

    localparam logic [7:0] ID = 8'b1000_0001;

    // ---------------- directed sequence ----------------
    initial begin
        tick(4); rst_n = 1'b1; tick(2);
        chk("R1", "adc_phase", adc_phase, 1);
        chk("R1", "drive_mode", drive_mode, 0);
        chk("R1", "pwr_mode", pwr_mode, 0);
        chk("R1", "shut_hcount", shut_hcount, 0);

        send_bits(ctl_word(3'b010, 1, 1, 1, 1, 1, 2'b10, 2'b11, 2'b01, ID, 2'b00), 48);
        chk("R7", "pwr sleep at strobe", pwr_mode, 1);
        chk("R6", "mode before frame event", drive_mode, 0);
        chk("R8", "phase before line event", adc_phase, 1);
        line_pulse(1'b0);
        chk("R8", "phase after non-readout line", adc_phase, 1);
        line_pulse(1'b1);
        chk("R8", "phase after readout line", adc_phase, 3);
        chk("R8", "exp_select", exp_select, 1);
        chk("R8", "clamp_pattern", clamp_pattern, 2);
        chk("R6", "mode after line event only", drive_mode, 0);
        frame_pulse();
        chk("R6", "drive_mode", drive_mode, 2);
        chk("R6", "pal_pattern", pal_pattern, 1);

        send_bits(sht_word(10'h155, 12'hAA3, 10'h3FF), 48);
        line_pulse(1'b1);
        chk("R9", "shut_vcount", shut_vcount, 10'h155);
        chk("R9", "shut_hcount", shut_hcount, 12'hAA3);
        chk("R9", "shut_vplace", shut_vplace, 10'h3FF);
        chk("R4", "control untouched by shutter frame", adc_phase, 3);

        send_bits(ctl_word(3'b101, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b11, 8'b1000_0000, 2'b00), 48);
        chk("R3", "pwr after bad id", pwr_mode, 1);
        line_pulse(1'b1); frame_pulse();
        chk("R3", "phase after bad id", adc_phase, 3);
        chk("R3", "mode after bad id", drive_mode, 2);

        send_bits(ctl_word(3'b101, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b11, ID, 2'b10), 48);
        send_bits(ctl_word(3'b101, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b11, ID, 2'b11), 48);
        chk("R4", "pwr after test category", pwr_mode, 1);
        line_pulse(1'b1); frame_pulse();
        chk("R4", "phase after test category", adc_phase, 3);
        chk("R4", "vcount after test category", shut_vcount, 10'h155);

        send_bits(ctl_word(3'b101, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b11, ID, 2'b00), 47);
        chk("R2", "pwr after 47 bits", pwr_mode, 1);
        send_bits(ctl_word(3'b101, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b11, ID, 2'b00), 49);
        chk("R2", "pwr after 49 bits", pwr_mode, 1);
        line_pulse(1'b1); frame_pulse();
        chk("R2", "phase after short/long frames", adc_phase, 3);
        chk("R2", "mode after short/long frames", drive_mode, 2);

        send_bits(ctl_word(3'b001, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, ID, 2'b00), 48);
        chk("R7", "pwr run", pwr_mode, 0);
        send_bits(ctl_word(3'b011, 0, 0, 0, 0, 0, 2'b01, 2'b10, 2'b00, ID, 2'b00), 48);
        line_pulse(1'b1); frame_pulse();
        chk("R5", "phase last write wins", adc_phase, 2);
        chk("R5", "mode last write wins", drive_mode, 3);

        upd_hold = 1'b1;
        send_bits(ctl_word(3'b100, 1, 0, 0, 0, 0, 2'b00, 2'b01, 2'b11, ID, 2'b00), 48);
        chk("R7", "standby applies during hold", pwr_mode, 2);
        line_pulse(1'b1); frame_pulse();
        chk("R10", "phase held", adc_phase, 2);
        chk("R10", "mode held", drive_mode, 3);
        upd_hold = 1'b0; tick(1);
        line_pulse(1'b1); frame_pulse();
        chk("R10", "phase after release", adc_phase, 1);
        chk("R10", "mode after release", drive_mode, 4);

        send_bits(ctl_word(3'b100, 1, 0, 0, 0, 0, 2'b00, 2'b01, 2'b10, ID, 2'b00), 48);
        chk("R7", "pwr x0 is run", pwr_mode, 0);

        tick(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule